// File: doc/BRIEF.md
# Stacked Dual-Flash Chip-Select Router

This block connects a controller that drives a single chip select to a pair of identical serial flash devices. The two devices share the clock and data lines, and each one has its own select line. A configuration register holds two bits. The first enables two-device operation. The second picks the upper device when a transaction takes its page from the register. Each transaction request carries a start pulse, an end pulse, a linear byte address and a routing mode. The block resolves the target device once, at start. It turns the linear address into an address local to that device, and it holds one active-low select low until the transaction ends.

There are three routing modes. In register mode the page bit decides. In automatic mode the block compares the address with half the combined capacity: an address in the upper half goes to the upper device with that half subtracted, and an address in the lower half passes through unchanged. In repeat mode the block reuses the device of the previous accepted transaction, so that a status poll after a program or erase reaches the same device. With two-device operation disabled, only the lower select is ever driven and the address is cut to the device width. The block also reports the addressable capacity.

Top module: `stack_cs_router`

## Requirements
- R1: After reset both selects (`cs_lo_n`, `cs_hi_n`) are high, `xfer_busy` is 0 and `dev_addr` is 0.
- R2: When configuration bit 30 (two-device enable) is 0 at start, only `cs_lo_n` goes low for the transaction, whatever the mode or bit 28. `dev_addr` is then `req_addr[23:0]`.
- R3: In register mode (`req_mode` 0, or 3, which is treated the same) with bit 30 set, bit 28 = 0 routes to the lower device and bit 28 = 1 to the upper device. `dev_addr` is `req_addr[23:0]`.
- R4: In automatic mode (`req_mode` 1) with bit 30 set, an address at or above 2^24 routes to the upper device with 2^24 subtracted. A lower address routes to the lower device unchanged. Bit 28 is ignored in this mode. Bits [23:16] of `dev_addr` are the byte sent first.
- R5: In repeat mode (`req_mode` 2) the device is the one used by the previous accepted transaction, the lower device after reset, and `dev_addr` is `req_addr[23:0]`.
- R6: When a start is sampled while idle, exactly one select is low from the next cycle on. When an end is sampled while busy, both selects are high from the next cycle on. The two selects are never low together.
- R7: While a transaction is active, the selected device and `dev_addr` stay constant.
- R8: A configuration write made while a transaction is active does not affect that transaction. It applies from the next start. A write in the same cycle as a start applies to that start.
- R9: A start while busy is ignored. An end while idle is ignored. A start and an end in the same idle cycle open a transaction.
- R10: `total_bytes` is 2^24 when bit 30 of the register is 0 and 2^25 when it is 1. It follows the register one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration data; bit 30 enables two devices, bit 28 selects the upper page |
| req_start | input | 1 | Transaction start pulse |
| req_end | input | 1 | Transaction end pulse |
| req_mode | input | 2 | Routing: 0 register, 1 automatic, 2 repeat, 3 register |
| req_addr | input | 25 | Linear byte address over the combined space |
| cs_lo_n | output | 1 | Active-low select of the lower device |
| cs_hi_n | output | 1 | Active-low select of the upper device |
| xfer_busy | output | 1 | A transaction is open |
| dev_addr | output | 24 | Device-local address, bits [23:16] sent first |
| total_bytes | output | 26 | Addressable capacity in bytes |

## Verification
A configuration write and a transaction start can happen in the same cycle, and a write can also arrive while a select is held low. The bench does both. It pulses `cfg_we` in the same cycle as `req_start` and expects the new page bit to decide that transaction. It also writes a reversed page bit partway through an open transaction and expects the select and address to stay unchanged until the end, with the new value taking effect only at the following start. A stray start raised during an open transaction is judged the same way, by the held select and address.

// File: rtl/stack_cs_pkg.sv
package stack_cs_pkg;

  // Positions decoded by the configuration register
  localparam int CFG_TWO_DEV_BIT = 30;
  localparam int CFG_UPPER_BIT   = 28;

  // Routing mode carried with each transaction request
  typedef enum logic [1:0] {
    ROUTE_REG    = 2'd0,
    ROUTE_AUTO   = 2'd1,
    ROUTE_REPEAT = 2'd2,
    ROUTE_RSVD   = 2'd3
  } route_mode_e;

  // Resolved configuration seen by one start
  typedef struct packed {
    logic two_dev;
    logic upper;
  } route_cfg_t;

endpackage

// File: rtl/stack_cfg_reg.sv
module stack_cfg_reg
  import stack_cs_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output route_cfg_t       cfg_q,
  output route_cfg_t       cfg_eff
);

  route_cfg_t wr_cfg;
  logic       unused_wbits;

  always_comb begin
    wr_cfg.two_dev = wdata[CFG_TWO_DEV_BIT];
    wr_cfg.upper   = wdata[CFG_UPPER_BIT];
  end

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (we) cfg_q <= wr_cfg;
  end

  // A write in the same cycle as a start is seen by that start
  assign cfg_eff = we ? wr_cfg : cfg_q;

  // R10
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q.two_dev == $past(wdata[CFG_TWO_DEV_BIT])));

endmodule

// File: rtl/stack_addr_xlate.sv
module stack_addr_xlate
  import stack_cs_pkg::*;
#(
  parameter int DEV_AW = 24
) (
  input  route_cfg_t        cfg,
  input  logic              last_upper,
  input  logic [1:0]        mode,
  input  logic [DEV_AW:0]   lin_addr,
  output logic              to_upper,
  output logic [DEV_AW-1:0] local_addr
);

  localparam int LIN_AW = DEV_AW + 1;
  localparam logic [LIN_AW-1:0] HALF_CAP = {1'b1, {DEV_AW{1'b0}}};

  function automatic logic in_upper_half(input logic [LIN_AW-1:0] a);
    return a >= HALF_CAP;
  endfunction

  function automatic logic [DEV_AW-1:0] strip_half(input logic [LIN_AW-1:0] a);
    logic [LIN_AW-1:0] d;
    d = a - HALF_CAP;
    return d[DEV_AW-1:0];
  endfunction

  function automatic logic [DEV_AW-1:0] clip(input logic [LIN_AW-1:0] a);
    return a[DEV_AW-1:0];
  endfunction

  route_mode_e m;
  assign m = route_mode_e'(mode);

  always_comb begin
    to_upper   = 1'b0;
    local_addr = clip(lin_addr);
    if (cfg.two_dev) begin
      unique case (m)
        ROUTE_AUTO: begin
          to_upper = in_upper_half(lin_addr);
          if (to_upper) local_addr = strip_half(lin_addr);
        end
        ROUTE_REPEAT: to_upper = last_upper;
        default:      to_upper = cfg.upper;
      endcase
    end
  end

endmodule

// File: rtl/stack_cs_seq.sv
module stack_cs_seq #(
  parameter int DEV_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              two_dev_in,
  input  logic              upper_in,
  input  logic [DEV_AW-1:0] addr_in,
  output logic              active,
  output logic              upper_q,
  output logic              two_dev_q,
  output logic [DEV_AW-1:0] addr_q,
  output logic              cs_lo_n,
  output logic              cs_hi_n
);

  logic accept;
  logic release_x;

  assign accept    = start && !active;
  assign release_x = stop && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      upper_q   <= 1'b0;
      two_dev_q <= 1'b0;
      addr_q    <= '0;
    end else if (accept) begin
      active    <= 1'b1;
      upper_q   <= two_dev_in && upper_in;
      two_dev_q <= two_dev_in;
      addr_q    <= addr_in;
    end else if (release_x) begin
      active    <= 1'b0;
    end
  end

  assign cs_lo_n = !(active && !upper_q);
  assign cs_hi_n = !(active && upper_q);

  // R6
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!cs_lo_n || !cs_hi_n));

  // R6
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_x |=> (cs_lo_n && cs_hi_n));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(addr_q) && $stable(upper_q)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active && !stop) |=> ($stable(addr_q) && active));

endmodule

// File: rtl/stack_cs_router.sv
module stack_cs_router
  import stack_cs_pkg::*;
#(
  parameter int DEV_AW = 24,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_start,
  input  logic              req_end,
  input  logic [1:0]        req_mode,
  input  logic [DEV_AW:0]   req_addr,
  output logic              cs_lo_n,
  output logic              cs_hi_n,
  output logic              xfer_busy,
  output logic [DEV_AW-1:0] dev_addr,
  output logic [DEV_AW+1:0] total_bytes
);

  localparam int CAP_W = DEV_AW + 2;
  localparam logic [CAP_W-1:0] ONE_DEV_CAP = CAP_W'(1) << DEV_AW;

  route_cfg_t        cfg_q;
  route_cfg_t        cfg_eff;
  logic              route_upper;
  logic [DEV_AW-1:0] route_addr;
  logic              last_upper;
  logic              lat_two_dev;

  stack_cfg_reg #(.CFG_W(CFG_W)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg_q   (cfg_q),
    .cfg_eff (cfg_eff)
  );

  stack_addr_xlate #(.DEV_AW(DEV_AW)) xlate_i (
    .cfg        (cfg_eff),
    .last_upper (last_upper),
    .mode       (req_mode),
    .lin_addr   (req_addr),
    .to_upper   (route_upper),
    .local_addr (route_addr)
  );

  stack_cs_seq #(.DEV_AW(DEV_AW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_start),
    .stop       (req_end),
    .two_dev_in (cfg_eff.two_dev),
    .upper_in   (route_upper),
    .addr_in    (route_addr),
    .active     (xfer_busy),
    .upper_q    (last_upper),
    .two_dev_q  (lat_two_dev),
    .addr_q     (dev_addr),
    .cs_lo_n    (cs_lo_n),
    .cs_hi_n    (cs_hi_n)
  );

  assign total_bytes = cfg_q.two_dev ? (ONE_DEV_CAP << 1) : ONE_DEV_CAP;

  // R2
  single_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !lat_two_dev) |-> cs_hi_n);

  // R6
  excl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo_n || cs_hi_n));

  // R8
  mid_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && xfer_busy && !req_end) |=> ($stable(cs_lo_n) && $stable(cs_hi_n)));

  // R4
  auto_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !xfer_busy && cfg_eff.two_dev && req_mode == 2'd1 && req_addr[DEV_AW])
      |=> !cs_hi_n);

endmodule

// File: tb/stack_cs_router_tb_top.sv
module stack_cs_router_tb_top;

  localparam int AW = 24;

  typedef struct {
    logic        hi;
    logic [23:0] addr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_start = 1'b0;
  logic        req_end = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [24:0] req_addr = '0;
  logic        cs_lo_n, cs_hi_n, xfer_busy;
  logic [23:0] dev_addr;
  logic [25:0] total_bytes;

  int n_chk = 0;
  int n_bad = 0;
  exp_t sb[$];
  exp_t cur;
  bit   was_busy = 0;
  bit   done = 0;

  // bench model state
  bit m_two = 0, m_up = 0, m_last = 0;

  always #4 clk = ~clk;

  stack_cs_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_start(req_start), .req_end(req_end), .req_mode(req_mode),
    .req_addr(req_addr), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
    .xfer_busy(xfer_busy), .dev_addr(dev_addr), .total_bytes(total_bytes)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [24:0] a, input logic [1:0] m, input string tag);
    exp_t e;
    e.tag = tag;
    e.addr = a[23:0];
    e.hi = 1'b0;
    if (m_two) begin
      if (m == 2'd1) begin
        e.hi = (a > 25'h0FFFFFF);
        if (e.hi) e.addr = 24'(a ^ 25'h1000000);
      end else if (m == 2'd2) e.hi = m_last;
      else e.hi = m_up;
    end
    return e;
  endfunction

  function automatic logic [31:0] cfgword(input bit two, input bit up);
    return (32'(two) << 30) | (32'(up) << 28) | 32'h0500_00F3;
  endfunction

  task automatic wr_cfg(input bit two, input bit up);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = cfgword(two, up);
    @(negedge clk);
    cfg_we = 0;
    m_two = two; m_up = up;
  endtask

  // kind: 0 plain, 1 write in start cycle, 2 write mid-transfer, 3 stray start mid, 4 end with start
  task automatic xfer(input logic [24:0] a, input logic [1:0] m, input int kind,
                      input bit wtwo, input bit wup, input string tag);
    exp_t e;
    @(negedge clk);
    if (kind == 1) begin
      cfg_we = 1; cfg_wdata = cfgword(wtwo, wup);
      m_two = wtwo; m_up = wup;
    end
    e = predict(a, m, tag);
    sb.push_back(e);
    m_last = e.hi;
    req_start = 1; req_mode = m; req_addr = a;
    if (kind == 4) req_end = 1;
    @(negedge clk);
    req_start = 0; cfg_we = 0; req_end = 0;
    req_addr = 25'h1555555; req_mode = 2'd1;
    @(negedge clk);
    if (kind == 2) begin
      cfg_we = 1; cfg_wdata = cfgword(wtwo, wup);
      m_two = wtwo; m_up = wup;
      @(negedge clk);
      cfg_we = 0;
    end
    if (kind == 3) begin
      req_start = 1; req_addr = 25'h1ABCDEF; req_mode = 2'd1;
      @(negedge clk);
      req_start = 0;
    end
    repeat (2) @(negedge clk);
    req_end = 1;
    @(negedge clk);
    req_end = 0;
    chk(cs_lo_n && cs_hi_n && !xfer_busy, {tag, " R6 release"}, {cs_lo_n, cs_hi_n}, 2'b11);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit busy;
      busy = !cs_lo_n || !cs_hi_n;
      if (busy && !was_busy) begin
        if (sb.size() == 0) chk(0, "R6 unexpected select", {cs_lo_n, cs_hi_n}, 2'b11);
        else begin
          cur = sb.pop_front();
          chk(cs_hi_n == !cur.hi && cs_lo_n == cur.hi, {cur.tag, " device"},
              {cs_lo_n, cs_hi_n}, {cur.hi, !cur.hi});
          chk(dev_addr == cur.addr, {cur.tag, " address"}, dev_addr, cur.addr);
        end
      end else if (busy) begin
        chk(cs_hi_n == !cur.hi && dev_addr == cur.addr, {cur.tag, " R7 hold"},
            {cs_lo_n, cs_hi_n, dev_addr}, {cur.hi, !cur.hi, cur.addr});
      end
      was_busy = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_lo_n && cs_hi_n && !xfer_busy && dev_addr == 0, "R1 reset",
        {cs_lo_n, cs_hi_n, xfer_busy, dev_addr}, {3'b110, 24'h0});
    rst_n = 1;
    @(negedge clk);
    chk(total_bytes == 26'h1000000, "R10 single capacity", total_bytes, 26'h1000000);

    // single-device mode, page bit set but must not matter
    wr_cfg(0, 1);
    xfer(25'h1234567, 2'd0, 0, 0, 0, "R2 single reg");
    xfer(25'h1800000, 2'd1, 0, 0, 0, "R2 single auto");
    xfer(25'h0000100, 2'd2, 0, 0, 0, "R2 single repeat");

    wr_cfg(1, 0);
    chk(total_bytes == 26'h2000000, "R10 stacked capacity", total_bytes, 26'h2000000);
    xfer(25'h00ABCDE, 2'd0, 0, 0, 0, "R3 reg lower");
    wr_cfg(1, 1);
    xfer(25'h00ABCDE, 2'd0, 0, 0, 0, "R3 reg upper");
    xfer(25'h1000010, 2'd3, 0, 0, 0, "R3 mode3 upper");

    xfer(25'h1000000, 2'd1, 0, 0, 0, "R4 auto half");
    xfer(25'h0FFFFFF, 2'd1, 0, 0, 0, "R4 auto below half");
    xfer(25'h1FFFFFF, 2'd1, 0, 0, 0, "R4 auto top");

    xfer(25'h0000042, 2'd2, 0, 0, 0, "R5 repeat upper");
    xfer(25'h0000010, 2'd1, 0, 0, 0, "R4 auto low");
    xfer(25'h1000077, 2'd2, 0, 0, 0, "R5 repeat lower");

    wr_cfg(1, 0);
    xfer(25'h0000011, 2'd0, 2, 1, 1, "R8 mid write");
    xfer(25'h0000022, 2'd0, 0, 0, 0, "R8 next start");
    xfer(25'h0000033, 2'd0, 1, 1, 0, "R8 same cycle write");

    xfer(25'h0000044, 2'd0, 3, 1, 0, "R9 stray start");
    @(negedge clk);
    req_end = 1;
    @(negedge clk);
    req_end = 0;
    @(negedge clk);
    chk(cs_lo_n && cs_hi_n && !xfer_busy, "R9 idle end", {cs_lo_n, cs_hi_n}, 2'b11);
    xfer(25'h0000055, 2'd0, 4, 1, 0, "R9 start with end");
    wr_cfg(0, 0);
    chk(total_bytes == 26'h1000000, "R10 back to single", total_bytes, 26'h1000000);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R6 all transactions seen", sb.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule